// File: doc/BRIEF.md
# Cache Miss Line Fill Buffer

This block sits between a first-level data cache and the next memory level. It keeps track of the cache lines that are missing and being fetched. A miss from the load/store side either takes a free entry or joins the entry that already holds its line. Each new entry sends one line request downstream. The line then comes back as a series of 8-byte beats over a narrow path, and the block gathers those beats into a full 64-byte line. Beats for different entries may interleave. Within one line, the beats start at the word that caused the miss and wrap past the end of the line.

Each requested word goes back to the requester on its own response port as soon as its beat has arrived. The whole line is written to the cache only after every beat is in and every requested word has been returned. That write is a single transfer as wide as the line. The entry is free again in the cycle after the cache accepts the line.

Each entry runs a four-state machine:
- `ENT_IDLE` moves to `ENT_ASK` on allocation.
- `ENT_ASK` moves to `ENT_GATHER` when the downstream request is accepted.
- `ENT_GATHER` moves to `ENT_OFFER` once all beats are present, no requested word is still waiting, and no merge arrives in that cycle.
- `ENT_OFFER` moves back to `ENT_IDLE` when the cache accepts the line.

Top module: `linefill_buffer`

## Requirements
- R1: After reset, miss_ready is 1 and rsp_valid, dreq_valid and fill_valid are 0.
- R2: A miss to a line with no entry is accepted while a free entry exists. It causes exactly one downstream request, which carries:
  - the entry index;
  - the line address, miss_addr[31:6];
  - the critical word index, miss_addr[5:3].
- R3: While all ENTRIES entries are occupied, a miss to a line that has no entry sees miss_ready at 0.
- R4: A miss to a line whose entry is in ENT_ASK or ENT_GATHER is accepted even when every entry is occupied. It merges into that entry and makes no second downstream request.
- R5: A beat with beat number k for an entry holds line word (critical word + k) mod 8.
- R6: The word of every accepted miss is returned once on the response port. The response carries:
  - rsp_addr, the miss address with bits [2:0] forced to zero;
  - rsp_data, the beat data for that word.

  A miss to a word that is already waiting for return shares that return. No word is returned that was not requested.
- R7: A line is offered to the cache only after all 8 beats have arrived and every requested word of the line has been returned. Word w of fill_data sits at bits [64w+63:64w].
- R8: While fill_valid is 1 and fill_ready is 0, fill_valid stays 1 in the next cycle, and fill_line and fill_data stay unchanged.
- R9: An entry whose line is accepted at a clock edge is free from the next cycle, so a new miss can take it.
- R10: A miss to a line whose entry is in ENT_OFFER stalls until that entry is freed. No line is ever held by two entries.
- R11: While dreq_valid is 1 and dreq_ready is 0, dreq_valid stays 1 in the next cycle, and dreq_idx, dreq_line and dreq_crit stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | ADDR_W | Byte address of the missing access |
| miss_ready | output | 1 | Miss accepted this cycle |
| rsp_valid | output | 1 | Returned word present |
| rsp_addr | output | ADDR_W | Word-aligned address of returned word |
| rsp_data | output | 8*BEAT_BYTES | Returned word |
| dreq_valid | output | 1 | Downstream line request present |
| dreq_ready | input | 1 | Downstream accepts the request |
| dreq_idx | output | IDX_W | Entry index to tag returning beats |
| dreq_line | output | ADDR_W-OFF_W | Line address requested |
| dreq_crit | output | BW | Word index to send first |
| dbeat_valid | input | 1 | Response beat present |
| dbeat_idx | input | IDX_W | Entry the beat belongs to |
| dbeat_num | input | BW | Beat number within the line, from 0 |
| dbeat_data | input | 8*BEAT_BYTES | Beat payload |
| fill_valid | output | 1 | Full line offered to the cache |
| fill_ready | input | 1 | Cache accepts the line |
| fill_line | output | ADDR_W-OFF_W | Line address of the fill |
| fill_data | output | 8*LINE_BYTES | Whole line, word 0 in the low bits |

## Verification
The assertions assume that downstream beats arrive only for an entry whose request has been accepted. They also assume that each beat number comes once per request. The requester must take every response, since there is no back-pressure on that port.

The bench keeps to these rules by modelling the next memory level itself. It records each accepted request by entry index and sends that entry's beats in order, from 0 upward. It interleaves entries at random and never sends a beat for an index it has not seen requested.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE,
        ENT_ASK,
        ENT_GATHER,
        ENT_OFFER
    } ent_state_e;

endpackage

// File: rtl/lfb_prio.sv
// Lowest-index-first selector over a request vector.
module lfb_prio #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lfb_entry.sv
// One outstanding line: state machine, wanted/arrived word masks, line storage.
module lfb_entry
    import lfb_pkg::*;
#(
    parameter int LINE_W    = 26,
    parameter int BEATS     = 8,
    parameter int BEAT_BITS = 64,
    localparam int BW = $clog2(BEATS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_i,
    input  logic                       merge_i,
    input  logic [LINE_W-1:0]          line_i,
    input  logic [BW-1:0]              word_i,
    input  logic                       req_ack_i,
    input  logic                       beat_i,
    input  logic [BW-1:0]              beat_num_i,
    input  logic [BEAT_BITS-1:0]       beat_data_i,
    input  logic [BEATS-1:0]           clr_i,
    input  logic                       fill_ack_i,
    output ent_state_e                 state_o,
    output logic [LINE_W-1:0]          line_o,
    output logic [BW-1:0]              crit_o,
    output logic [BEATS-1:0]           want_o,
    output logic [BEATS-1:0]           have_o,
    output logic [BEATS*BEAT_BITS-1:0] data_o
);
    ent_state_e                 state_q, state_d;
    logic [LINE_W-1:0]          line_q;
    logic [BW-1:0]              crit_q;
    logic [BEATS-1:0]           want_q, have_q;
    logic [BEATS*BEAT_BITS-1:0] data_q;
    logic [BW-1:0]              pos;
    logic [BEATS-1:0]           set_mask;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE:   if (alloc_i)   state_d = ENT_ASK;
            ENT_ASK:    if (req_ack_i) state_d = ENT_GATHER;
            ENT_GATHER: if (&have_q && (want_q == '0) && !merge_i)
                            state_d = ENT_OFFER;
            ENT_OFFER:  if (fill_ack_i) state_d = ENT_IDLE;
            default:    state_d = ENT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_IDLE;
        else        state_q <= state_d;
    end

    assign pos      = crit_q + beat_num_i;
    assign set_mask = merge_i ? (BEATS'(1) << word_i) : '0;

    // Per-line bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            crit_q <= '0;
            want_q <= '0;
            have_q <= '0;
        end else if (alloc_i) begin
            line_q <= line_i;
            crit_q <= word_i;
            want_q <= BEATS'(1) << word_i;
            have_q <= '0;
        end else begin
            want_q <= (want_q | set_mask) & ~clr_i;
            if (beat_i) have_q <= have_q | (BEATS'(1) << pos);
        end
    end

    always_ff @(posedge clk) begin
        if (beat_i) data_q[pos*BEAT_BITS +: BEAT_BITS] <= beat_data_i;
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        line_o  = line_q;
        crit_o  = crit_q;
        want_o  = want_q;
        have_o  = have_q;
        data_o  = data_q;
    end
endmodule

// File: rtl/linefill_buffer.sv
module linefill_buffer
    import lfb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8,
    parameter int ENTRIES    = 12,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int WOFF_W    = $clog2(BEAT_BYTES),
    localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
    localparam int BW        = $clog2(BEATS),
    localparam int BEAT_BITS = 8 * BEAT_BYTES,
    localparam int LINE_BITS = 8 * LINE_BYTES,
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [ADDR_W-1:0]    miss_addr,
    output logic                 miss_ready,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [BEAT_BITS-1:0] rsp_data,
    output logic                 dreq_valid,
    input  logic                 dreq_ready,
    output logic [IDX_W-1:0]     dreq_idx,
    output logic [LINE_W-1:0]    dreq_line,
    output logic [BW-1:0]        dreq_crit,
    input  logic                 dbeat_valid,
    input  logic [IDX_W-1:0]     dbeat_idx,
    input  logic [BW-1:0]        dbeat_num,
    input  logic [BEAT_BITS-1:0] dbeat_data,
    output logic                 fill_valid,
    input  logic                 fill_ready,
    output logic [LINE_W-1:0]    fill_line,
    output logic [LINE_BITS-1:0] fill_data
);
    localparam int SLOTS  = ENTRIES * BEATS;
    localparam int SLOT_W = $clog2(SLOTS);

    ent_state_e           ent_state [ENTRIES];
    logic [LINE_W-1:0]    ent_line  [ENTRIES];
    logic [BW-1:0]        ent_crit  [ENTRIES];
    logic [BEATS-1:0]     ent_want  [ENTRIES];
    logic [BEATS-1:0]     ent_have  [ENTRIES];
    logic [LINE_BITS-1:0] ent_data  [ENTRIES];

    logic [ENTRIES-1:0] occ, offer, ask, match, free_vec;
    logic [SLOTS-1:0]   ent_want_flat, rdy_flat;
    logic [LINE_W-1:0]  miss_line;
    logic [BW-1:0]      miss_word;
    logic               unused_lowbits;
    logic               hit_live, hit_fill, accept;
    logic               free_any, match_any, ask_any, offer_any, rsp_any;
    logic [IDX_W-1:0]   free_idx, match_idx, ask_idx, offer_idx;
    logic [SLOT_W-1:0]  rsp_slot;
    logic [IDX_W-1:0]   r_ent;
    logic [BW-1:0]      r_word;
    logic               dreq_hold_q, fill_hold_q;
    logic [IDX_W-1:0]   dreq_held_q, fill_held_q, dreq_sel, fill_sel;

    assign miss_line      = miss_addr[ADDR_W-1:OFF_W];
    assign miss_word      = miss_addr[OFF_W-1:WOFF_W];
    assign unused_lowbits = ^miss_addr[WOFF_W-1:0] ^ match_any;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            occ[i]      = ent_state[i] != ENT_IDLE;
            offer[i]    = ent_state[i] == ENT_OFFER;
            ask[i]      = ent_state[i] == ENT_ASK;
            match[i]    = occ[i] && (ent_line[i] == miss_line);
            ent_want_flat[i*BEATS +: BEATS] = ent_want[i];
            rdy_flat[i*BEATS +: BEATS]      = ent_want[i] & ent_have[i];
        end
        free_vec = ~occ;
    end

    lfb_prio #(.W(ENTRIES)) u_free  (.req(free_vec), .any(free_any),  .idx(free_idx));
    lfb_prio #(.W(ENTRIES)) u_match (.req(match),    .any(match_any), .idx(match_idx));
    lfb_prio #(.W(ENTRIES)) u_ask   (.req(ask),      .any(ask_any),   .idx(ask_idx));
    lfb_prio #(.W(ENTRIES)) u_offer (.req(offer),    .any(offer_any), .idx(offer_idx));
    lfb_prio #(.W(SLOTS))   u_rsp   (.req(rdy_flat), .any(rsp_any),   .idx(rsp_slot));

    // Miss-side and selection outputs
    always_comb begin
        hit_live   = |(match & ~offer);
        hit_fill   = |(match & offer);
        miss_ready = hit_live || (!hit_fill && free_any);
        accept     = miss_valid && miss_ready;
        r_ent      = IDX_W'(rsp_slot >> BW);
        r_word     = rsp_slot[BW-1:0];
        dreq_sel   = dreq_hold_q ? dreq_held_q : ask_idx;
        dreq_valid = dreq_hold_q || ask_any;
        dreq_idx   = dreq_sel;
        dreq_line  = ent_line[dreq_sel];
        dreq_crit  = ent_crit[dreq_sel];
        fill_sel   = fill_hold_q ? fill_held_q : offer_idx;
        fill_valid = fill_hold_q || offer_any;
        fill_line  = ent_line[fill_sel];
        fill_data  = ent_data[fill_sel];
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        lfb_entry #(
            .LINE_W(LINE_W), .BEATS(BEATS), .BEAT_BITS(BEAT_BITS)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (accept && !hit_live && (free_idx == IDX_W'(g))),
            .merge_i    (accept && hit_live && (match_idx == IDX_W'(g))),
            .line_i     (miss_line),
            .word_i     (miss_word),
            .req_ack_i  (dreq_valid && dreq_ready && (dreq_sel == IDX_W'(g))),
            .beat_i     (dbeat_valid && (dbeat_idx == IDX_W'(g))),
            .beat_num_i (dbeat_num),
            .beat_data_i(dbeat_data),
            .clr_i      ((rsp_any && (r_ent == IDX_W'(g))) ? (BEATS'(1) << r_word) : '0),
            .fill_ack_i (fill_valid && fill_ready && (fill_sel == IDX_W'(g))),
            .state_o    (ent_state[g]),
            .line_o     (ent_line[g]),
            .crit_o     (ent_crit[g]),
            .want_o     (ent_want[g]),
            .have_o     (ent_have[g]),
            .data_o     (ent_data[g])
        );
    end

    // Handshake holds and the registered word return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq_hold_q <= 1'b0;
            dreq_held_q <= '0;
            fill_hold_q <= 1'b0;
            fill_held_q <= '0;
            rsp_valid   <= 1'b0;
            rsp_addr    <= '0;
            rsp_data    <= '0;
        end else begin
            dreq_hold_q <= dreq_valid && !dreq_ready;
            dreq_held_q <= dreq_sel;
            fill_hold_q <= fill_valid && !fill_ready;
            fill_held_q <= fill_sel;
            rsp_valid   <= rsp_any;
            rsp_addr    <= {ent_line[r_ent], r_word, WOFF_W'(0)};
            rsp_data    <= ent_data[r_ent][r_word*BEAT_BITS +: BEAT_BITS];
        end
    end
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
    parameter int ENTRIES   = 12,
    parameter int BEATS     = 8,
    parameter int IDX_W     = 4,
    parameter int LINE_W    = 26,
    parameter int BW        = 3,
    parameter int LINE_BITS = 512
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       dreq_valid,
    input logic                       dreq_ready,
    input logic [IDX_W-1:0]           dreq_idx,
    input logic [LINE_W-1:0]          dreq_line,
    input logic [BW-1:0]              dreq_crit,
    input logic                       fill_valid,
    input logic                       fill_ready,
    input logic [LINE_W-1:0]          fill_line,
    input logic [LINE_BITS-1:0]       fill_data,
    input logic [IDX_W-1:0]           fill_sel,
    input logic [ENTRIES-1:0]         occ,
    input logic [ENTRIES-1:0]         match,
    input logic [ENTRIES*BEATS-1:0]   ent_want_flat
);
    p_dreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_idx)
            && $stable(dreq_line) && $stable(dreq_crit));

    p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !fill_ready |=> fill_valid && $stable(fill_line)
            && $stable(fill_data));

    p_fill_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (ent_want_flat[fill_sel*BEATS +: BEATS] == '0));

    p_one_entry_per_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    p_free_after_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && fill_ready |=> !occ[$past(fill_sel)]);
endmodule

bind linefill_buffer lfb_checker #(
    .ENTRIES(ENTRIES), .BEATS(BEATS), .IDX_W(IDX_W),
    .LINE_W(LINE_W), .BW(BW), .LINE_BITS(LINE_BITS)
) u_lfb_checker (
    .clk(clk), .rst_n(rst_n),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_idx(dreq_idx),
    .dreq_line(dreq_line), .dreq_crit(dreq_crit),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line),
    .fill_data(fill_data), .fill_sel(fill_sel),
    .occ(occ), .match(match), .ent_want_flat(ent_want_flat)
);

// File: tb/test_linefill_buffer.sv
`timescale 1ns/1ps
module test_linefill_buffer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic miss_ready, rsp_valid, dreq_valid, fill_valid;
    logic [31:0] rsp_addr;
    logic [63:0] rsp_data;
    logic dreq_ready = 1'b0;
    logic [3:0] dreq_idx;
    logic [25:0] dreq_line, fill_line;
    logic [2:0] dreq_crit;
    logic dbeat_valid = 1'b0;
    logic [3:0] dbeat_idx = '0;
    logic [2:0] dbeat_num = '0;
    logic [63:0] dbeat_data = '0;
    logic fill_ready = 1'b0;
    logic [511:0] fill_data;

    always #2 clk = ~clk;

    linefill_buffer i_linefill_buffer (.*);

    int n_chk = 0, n_fail = 0, n_dreq = 0;
    bit live [logic [25:0]];
    int first_w [logic [25:0]];
    bit asked [logic [25:0]];
    bit exp_rsp [logic [31:0]];
    bit e_act [12];
    logic [25:0] e_line [12];
    logic [2:0] e_crit [12];
    int e_next [12];

    bit d_miss_v = 0, d_dreq_rdy = 0, d_fill_rdy = 0, last_acc = 0;
    logic [31:0] d_miss_addr = '0;
    int d_beats = 0;
    bit pd_stall = 0, pf_stall = 0;
    logic [3:0] pd_idx;
    logic [25:0] pd_line, pf_line;
    logic [2:0] pd_crit;
    logic [511:0] pf_data;

    function automatic logic [63:0] mem_word(logic [25:0] ln, logic [2:0] w);
        return {6'd0, ln, 24'hA5C35A, 5'd0, w};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic cycle();
        logic [25:0] ln;
        int j;
        @(negedge clk);
        miss_valid = d_miss_v;
        miss_addr  = d_miss_addr;
        dreq_ready = d_dreq_rdy;
        fill_ready = d_fill_rdy;
        dbeat_valid = 1'b0;
        if ($urandom_range(99) < d_beats) begin
            int start = $urandom_range(11);
            for (int k = 0; k < 12; k++) begin
                j = (start + k) % 12;
                if (e_act[j] && e_next[j] < 8) begin
                    dbeat_valid = 1'b1;
                    dbeat_idx   = 4'(j);
                    dbeat_num   = 3'(e_next[j]);
                    dbeat_data  = mem_word(e_line[j], 3'(e_crit[j] + 3'(e_next[j])));
                    e_next[j]++;
                    break;
                end
            end
        end
        #1;
        // R6: returned words
        if (rsp_valid) begin
            check(exp_rsp.exists(rsp_addr), "R6", "unrequested return", 64'(rsp_addr), 0);
            check(rsp_data == mem_word(rsp_addr[31:6], rsp_addr[5:3]), "R6", "return data",
                  rsp_data, mem_word(rsp_addr[31:6], rsp_addr[5:3]));
            if (exp_rsp.exists(rsp_addr)) exp_rsp.delete(rsp_addr);
        end
        if (pd_stall)
            check(dreq_valid && dreq_idx == pd_idx && dreq_line == pd_line && dreq_crit == pd_crit,
                  "R11", "request not held", 64'(dreq_line), 64'(pd_line));
        if (pf_stall)
            check(fill_valid && fill_line == pf_line && fill_data == pf_data,
                  "R8", "fill not held", 64'(fill_line), 64'(pf_line));
        // Miss side: R3 R9 occupancy prediction
        last_acc = miss_valid && miss_ready;
        if (miss_valid) begin
            ln = miss_addr[31:6];
            if (!live.exists(ln))
                check(miss_ready == (live.num() < 12), "R3 R9", "miss_ready vs occupancy",
                      64'(miss_ready), 64'(live.num() < 12));
            if (last_acc) begin
                if (!live.exists(ln)) begin
                    live[ln] = 1;
                    first_w[ln] = int'(miss_addr[5:3]);
                end
                exp_rsp[{miss_addr[31:3], 3'b000}] = 1;
            end
        end
        // R2 R4: downstream request
        if (dreq_valid && dreq_ready) begin
            n_dreq++;
            check(live.exists(dreq_line) && !asked.exists(dreq_line), "R2 R4",
                  "request for unknown or already requested line", 64'(dreq_line), 0);
            if (first_w.exists(dreq_line))
                check(int'(dreq_crit) == first_w[dreq_line], "R2", "critical word",
                      64'(dreq_crit), 64'(first_w[dreq_line]));
            check(!e_act[dreq_idx], "R2", "entry index in use", 64'(dreq_idx), 0);
            asked[dreq_line] = 1;
            e_act[dreq_idx]  = 1;
            e_line[dreq_idx] = dreq_line;
            e_crit[dreq_idx] = dreq_crit;
            e_next[dreq_idx] = 0;
        end
        // R5 R7: line write
        if (fill_valid && fill_ready) begin
            j = -1;
            for (int k = 0; k < 12; k++) if (e_act[k] && e_line[k] == fill_line) j = k;
            check(j >= 0, "R7", "fill of unknown line", 64'(fill_line), 0);
            if (j >= 0) begin
                check(e_next[j] == 8, "R7", "fill before all beats", 64'(e_next[j]), 8);
                e_act[j] = 0;
            end
            for (int w = 0; w < 8; w++) begin
                check(fill_data[w*64 +: 64] == mem_word(fill_line, 3'(w)), "R5", "fill word",
                      fill_data[w*64 +: 64], mem_word(fill_line, 3'(w)));
                check(!exp_rsp.exists({fill_line, 3'(w), 3'b000}), "R7",
                      "fill before word returned", 64'(w), 0);
            end
            live.delete(fill_line);
            asked.delete(fill_line);
            first_w.delete(fill_line);
        end
        pd_stall = dreq_valid && !dreq_ready;
        pd_idx = dreq_idx; pd_line = dreq_line; pd_crit = dreq_crit;
        pf_stall = fill_valid && !fill_ready;
        pf_line = fill_line; pf_data = fill_data;
    endtask

    task automatic drain();
        int guard = 0;
        d_miss_v = 0; d_dreq_rdy = 1; d_fill_rdy = 1; d_beats = 100;
        while ((live.num() > 0 || exp_rsp.num() > 0) && guard < 3000) begin
            cycle();
            guard++;
        end
        check(live.num() == 0 && exp_rsp.num() == 0, "R6", "drain incomplete",
              64'(live.num()), 0);
    endtask

    task automatic miss(logic [25:0] ln, logic [2:0] w);
        d_miss_v = 1;
        d_miss_addr = {ln, w, 3'(($urandom_range(7)))};
        cycle();
        d_miss_v = 0;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(miss_ready && !rsp_valid && !dreq_valid && !fill_valid, "R1", "reset outputs",
              {miss_ready, rsp_valid, dreq_valid, fill_valid}, 4'b1000);

        // R2 R5 R6 R7: single miss, critical word in the middle of the line
        miss(26'h100, 3'd5);
        check(last_acc, "R2", "first miss accepted", 64'(last_acc), 1);
        drain();

        // R4: merge while request still pending
        base = n_dreq;
        d_dreq_rdy = 0;
        miss(26'h200, 3'd2);
        miss(26'h200, 3'd6);
        check(last_acc, "R4", "merge accepted", 64'(last_acc), 1);
        miss(26'h200, 3'd6);
        drain();
        check(n_dreq == base + 1, "R4", "single request for merged line", 64'(n_dreq - base), 1);

        // R3: fill all entries, then a new line must stall; a merge still passes
        d_dreq_rdy = 0; d_beats = 0;
        for (int k = 0; k < 12; k++) miss(26'(26'h300 + k), 3'(k));
        miss(26'h3FF, 3'd0);
        check(!last_acc, "R3", "miss accepted while full", 64'(last_acc), 0);
        miss(26'h305, 3'd7);
        check(last_acc, "R4", "merge while full", 64'(last_acc), 1);
        drain();

        // R10 R9: miss to a line waiting for its write, then reuse after acceptance
        d_dreq_rdy = 1; d_beats = 100; d_fill_rdy = 0;
        miss(26'h400, 3'd3);
        repeat (30) cycle();
        check(fill_valid && fill_line == 26'h400, "R7", "line offered", 64'(fill_line), 26'h400);
        miss(26'h400, 3'd1);
        check(!last_acc, "R10", "miss to offered line accepted", 64'(last_acc), 0);
        d_fill_rdy = 1;
        miss(26'h400, 3'd1);
        check(!last_acc, "R9", "entry reused in acceptance cycle", 64'(last_acc), 0);
        miss(26'h400, 3'd1);
        check(last_acc, "R9 R10", "miss after free", 64'(last_acc), 1);
        drain();

        // Constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            d_miss_v    = $urandom_range(99) < 40;
            d_miss_addr = {26'(26'h2000 + $urandom_range(19)), 3'($urandom_range(7)),
                           3'($urandom_range(7))};
            d_dreq_rdy  = $urandom_range(99) < 70;
            d_fill_rdy  = $urandom_range(99) < 60;
            d_beats     = 60;
            cycle();
        end
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule